// File: doc/BRIEF.md
# Deflecting Inter-Ring Bridge Router

This block joins one local ring to the global ring of a two-level hierarchical ring network-on-chip. Neither ring holds a flit anywhere: on every clock the bridge accepts one slot from each ring and hands a slot onward one hop later. A flit whose destination ring differs from the ring it is riding is copied into a small transfer queue for that direction and removed from its ring. Queued flits wait until an empty slot passes on the other ring, and only then are they placed onto it. Flits already on a ring always win over queued flits.

When a flit must change rings but the matching queue is full, the bridge leaves it on its present ring, unchanged. The flit travels a full lap and tries again the next time it reaches the bridge. Each such deflection raises a one-cycle pulse that travels alongside the deflected slot. A flit is a packed word, MSB first: a valid bit (bit 22), a 2-bit destination ring id (bits 21:20), a 4-bit destination node id (bits 19:16) and a 16-bit payload (bits 15:0). The bridge compares only the valid bit and the ring id with its own local ring id.

Top module: `ring_bridge`

## Requirements
- R1: A synchronous active-high reset empties both transfer queues and clears both output slots and both deflect pulses. After reset is released with idle rings, no queued flit from before the reset ever appears.
- R2: A valid flit that does not change rings (on the local ring: ring id equal to LOCAL_RING_ID; on the global ring: ring id not equal to it) appears unchanged on the same ring's output one cycle after it is presented.
- R3: A valid local-ring flit whose ring id differs from LOCAL_RING_ID, with room in the local-to-global queue, leaves the local output slot empty on the next cycle and appears on the global output one cycle after that if the global input slot is empty.
- R4: A valid global-ring flit whose ring id equals LOCAL_RING_ID, with room in the global-to-local queue, leaves the global output slot empty on the next cycle and appears on the local output one cycle after that if the local input slot is empty.
- R5: A queued flit is placed onto a ring only into an empty slot; while every incoming slot of that ring is occupied by passing traffic, the passing flits go through unaltered and the queued flit waits.
- R6: Each transfer queue holds XFER_DEPTH (4) flits. A flit that must change rings while its queue is full is sent on along its own ring unchanged one cycle later, and that ring's deflect output is high for exactly that cycle.
- R7: A deflected flit presented again after the queue has room is transferred normally, with no deflect pulse.
- R8: Flits leave each transfer queue in the order they entered it.
- R9: No flit is lost or duplicated: each flit presented to the bridge leaves on exactly one output exactly once per successful pass.
- R10: The full decision uses the queue state at the start of the cycle: a flit arriving in the same cycle that the queue head is injected onto the other ring is still deflected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| loc_in | input | 23 | Slot arriving from the local ring |
| glb_in | input | 23 | Slot arriving from the global ring |
| loc_out | output | 23 | Slot leaving onto the local ring (registered) |
| glb_out | output | 23 | Slot leaving onto the global ring (registered) |
| loc_deflect | output | 1 | High for the cycle a deflected flit occupies loc_out |
| glb_deflect | output | 1 | High for the cycle a deflected flit occupies glb_out |

## Verification
The two functions that can meet in one cycle are the head of a full queue being injected onto the far ring and a new flit needing that same queue. The bench saturates the global ring while it fills the local-to-global queue, then frees the global ring in the very cycle the next transferring flit arrives. It expects that flit to be deflected even though the queue drains by one at the same edge, and expects the oldest queued flit on the global output. The bench then feeds the deflected flits back and confirms that they transfer in order, each exactly once.

// File: rtl/ring_bridge_pkg.sv
package ring_bridge_pkg;

    localparam int RING_W = 2;
    localparam int NODE_W = 4;
    localparam int DATA_W = 16;

    // valid is the MSB, then ring id, node id, payload
    typedef struct packed {
        logic              valid;
        logic [RING_W-1:0] ring;
        logic [NODE_W-1:0] node;
        logic [DATA_W-1:0] data;
    } flit_t;

    localparam int FLIT_W = $bits(flit_t);

    localparam flit_t EMPTY_SLOT = '0;

    // true when a flit arriving on the given ring must cross to the other ring
    function automatic logic must_cross(flit_t f, logic on_global,
                                        logic [RING_W-1:0] local_id);
        if (!f.valid)
            return 1'b0;
        return on_global ? (f.ring == local_id) : (f.ring != local_id);
    endfunction

endpackage

// File: rtl/bridge_xfer_fifo.sv
module bridge_xfer_fifo
    import ring_bridge_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  flit_t din,
    input  logic  pop,
    output flit_t dout,
    output logic  full,
    output logic  empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    flit_t         mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt, cnt_nx;
    logic          do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        cnt_nx = cnt;
        if (do_push && !do_pop)
            cnt_nx = cnt + 1'b1;
        else if (do_pop && !do_push)
            cnt_nx = cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            full   <= 1'b0;
            empty  <= 1'b1;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            cnt   <= cnt_nx;
            full  <= (cnt_nx == FULL_CNT);
            empty <= (cnt_nx == '0);
        end
    end

    assign dout = mem[rd_ptr];

endmodule

// File: rtl/bridge_ring_stage.sv
module bridge_ring_stage
    import ring_bridge_pkg::*;
#(
    parameter bit                ON_GLOBAL     = 1'b0,
    parameter logic [RING_W-1:0] LOCAL_RING_ID = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  flit_t slot_in,
    input  logic  exit_full,
    output logic  exit_push,
    output flit_t exit_flit,
    input  flit_t inj_head,
    input  logic  inj_empty,
    output logic  inj_pop,
    output flit_t slot_out,
    output logic  deflect
);

    logic  crossing, blocked, keep;
    flit_t slot_nx;

    always_comb begin
        crossing  = must_cross(slot_in, ON_GLOBAL, LOCAL_RING_ID);
        blocked   = crossing && exit_full;
        exit_push = crossing && !exit_full;
        exit_flit = slot_in;
        // on-ring traffic that stays (passing or deflected) owns the slot
        keep      = (slot_in.valid && !crossing) || blocked;
        inj_pop   = !keep && !inj_empty;
        if (keep)
            slot_nx = slot_in;
        else if (inj_pop)
            slot_nx = inj_head;
        else
            slot_nx = EMPTY_SLOT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_out <= EMPTY_SLOT;
            deflect  <= 1'b0;
        end else begin
            slot_out <= slot_nx;
            deflect  <= blocked;
        end
    end

endmodule

// File: rtl/ring_bridge.sv
module ring_bridge
    import ring_bridge_pkg::*;
#(
    parameter logic [RING_W-1:0] LOCAL_RING_ID = 2'd0,
    parameter int                XFER_DEPTH    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FLIT_W-1:0] loc_in,
    input  logic [FLIT_W-1:0] glb_in,
    output logic [FLIT_W-1:0] loc_out,
    output logic [FLIT_W-1:0] glb_out,
    output logic              loc_deflect,
    output logic              glb_deflect
);

    // index 0: local ring, index 1: global ring
    // queue k holds flits that left ring k and wait for ring 1-k
    flit_t      slot_in   [2];
    flit_t      slot_out  [2];
    flit_t      exit_flit [2];
    flit_t      q_head    [2];
    logic [1:0] q_full, q_empty, q_push, q_pop, defl;

    assign slot_in[0] = flit_t'(loc_in);
    assign slot_in[1] = flit_t'(glb_in);

    for (genvar r = 0; r < 2; r++) begin : g_ring
        bridge_ring_stage #(
            .ON_GLOBAL     (r == 1),
            .LOCAL_RING_ID (LOCAL_RING_ID)
        ) u_stage (
            .clk       (clk),
            .rst       (rst),
            .slot_in   (slot_in[r]),
            .exit_full (q_full[r]),
            .exit_push (q_push[r]),
            .exit_flit (exit_flit[r]),
            .inj_head  (q_head[1-r]),
            .inj_empty (q_empty[1-r]),
            .inj_pop   (q_pop[1-r]),
            .slot_out  (slot_out[r]),
            .deflect   (defl[r])
        );

        bridge_xfer_fifo #(
            .DEPTH (XFER_DEPTH)
        ) u_queue (
            .clk   (clk),
            .rst   (rst),
            .push  (q_push[r]),
            .din   (exit_flit[r]),
            .pop   (q_pop[r]),
            .dout  (q_head[r]),
            .full  (q_full[r]),
            .empty (q_empty[r])
        );
    end

    assign loc_out     = slot_out[0];
    assign glb_out     = slot_out[1];
    assign loc_deflect = defl[0];
    assign glb_deflect = defl[1];

endmodule

// File: rtl/ring_bridge_chk.sv
module ring_bridge_chk
    import ring_bridge_pkg::*;
#(
    parameter logic [RING_W-1:0] LOCAL_RING_ID = 2'd0
) (
    input logic              clk,
    input logic              rst,
    input logic [FLIT_W-1:0] loc_in,
    input logic [FLIT_W-1:0] glb_in,
    input logic [FLIT_W-1:0] loc_out,
    input logic [FLIT_W-1:0] glb_out,
    input logic              loc_deflect,
    input logic              glb_deflect
);

    flit_t li, gi, lo, go;
    assign li = flit_t'(loc_in);
    assign gi = flit_t'(glb_in);
    assign lo = flit_t'(loc_out);
    assign go = flit_t'(glb_out);

    // R2
    loc_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (li.valid && li.ring == LOCAL_RING_ID) |=> (loc_out == $past(loc_in)));

    // R2
    glb_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (gi.valid && gi.ring != LOCAL_RING_ID) |=> (glb_out == $past(glb_in)));

    // R3
    loc_leave_chk: assert property (@(posedge clk) disable iff (rst)
        (li.valid && li.ring != LOCAL_RING_ID)
        |=> (loc_deflect || !lo.valid || lo.ring == LOCAL_RING_ID));

    // R4
    glb_leave_chk: assert property (@(posedge clk) disable iff (rst)
        (gi.valid && gi.ring == LOCAL_RING_ID)
        |=> (glb_deflect || !go.valid || go.ring != LOCAL_RING_ID));

    // R6
    loc_defl_chk: assert property (@(posedge clk) disable iff (rst)
        loc_deflect |-> (lo.valid && lo.ring != LOCAL_RING_ID));

    // R6
    glb_defl_chk: assert property (@(posedge clk) disable iff (rst)
        glb_deflect |-> (go.valid && go.ring == LOCAL_RING_ID));

endmodule

bind ring_bridge ring_bridge_chk #(
    .LOCAL_RING_ID (LOCAL_RING_ID)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .loc_in      (loc_in),
    .glb_in      (glb_in),
    .loc_out     (loc_out),
    .glb_out     (glb_out),
    .loc_deflect (loc_deflect),
    .glb_deflect (glb_deflect)
);

// File: tb/ring_bridge_test.sv
module ring_bridge_test;
    import ring_bridge_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [FLIT_W-1:0] loc_in = '0;
    logic [FLIT_W-1:0] glb_in = '0;
    logic [FLIT_W-1:0] loc_out, glb_out;
    logic              loc_deflect, glb_deflect;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ring_bridge #(.LOCAL_RING_ID(2'd0), .XFER_DEPTH(4)) uut (
        .clk         (clk),
        .rst         (rst),
        .loc_in      (loc_in),
        .glb_in      (glb_in),
        .loc_out     (loc_out),
        .glb_out     (glb_out),
        .loc_deflect (loc_deflect),
        .glb_deflect (glb_deflect)
    );

    function automatic flit_t mk(input logic [1:0] ring, input logic [15:0] data);
        flit_t f;
        f.valid = 1'b1;
        f.ring  = ring;
        f.node  = data[3:0];
        f.data  = data;
        return f;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [FLIT_W-1:0] act, input logic [FLIT_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // present one slot per ring, then wait past the edge that consumes them
    task automatic step(input flit_t l, input flit_t g);
        loc_in = l;
        glb_in = g;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset;
        rst = 1'b1;
        step(EMPTY_SLOT, EMPTY_SLOT);
        step(EMPTY_SLOT, EMPTY_SLOT);
        rst = 1'b0;
    endtask

    task automatic t_reset;
        // R1: park two flits in the local-to-global queue, then reset
        step(mk(2'd1, 16'h0A01), mk(2'd3, 16'h0B01));
        step(mk(2'd1, 16'h0A02), mk(2'd3, 16'h0B02));
        rst = 1'b1;
        step(EMPTY_SLOT, EMPTY_SLOT);
        check(loc_out == '0 && glb_out == '0, "R1 slots cleared", {loc_out}, '0);
        check(!loc_deflect && !glb_deflect, "R1 deflect cleared",
              {21'd0, loc_deflect, glb_deflect}, '0);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step(EMPTY_SLOT, EMPTY_SLOT);
            check(glb_out == '0, "R1 queue emptied", glb_out, '0);
        end
    endtask

    task automatic t_pass;
        flit_t a, b;
        a = mk(2'd0, 16'h1111);
        b = mk(2'd2, 16'h2222);
        step(a, b);
        check(loc_out == a, "R2 local pass", loc_out, a);
        check(glb_out == b, "R2 global pass", glb_out, b);
        step(EMPTY_SLOT, EMPTY_SLOT);
    endtask

    task automatic t_cross;
        flit_t a, b;
        a = mk(2'd1, 16'h3333);
        b = mk(2'd0, 16'h4444);
        step(a, EMPTY_SLOT);
        check(loc_out == '0, "R3 removed from local", loc_out, '0);
        step(EMPTY_SLOT, EMPTY_SLOT);
        check(glb_out == a, "R3 appears on global", glb_out, a);
        step(EMPTY_SLOT, b);
        check(glb_out == '0, "R4 removed from global", glb_out, '0);
        step(EMPTY_SLOT, EMPTY_SLOT);
        check(loc_out == b, "R4 appears on local", loc_out, b);
        step(EMPTY_SLOT, EMPTY_SLOT);
    endtask

    task automatic t_priority;
        flit_t x;
        x = mk(2'd2, 16'h5555);
        step(x, mk(2'd3, 16'h5001));
        check(glb_out == mk(2'd3, 16'h5001), "R5 passing kept", glb_out, mk(2'd3, 16'h5001));
        for (int i = 2; i < 4; i++) begin
            step(EMPTY_SLOT, mk(2'd3, 16'(16'h5000 + i)));
            check(glb_out == mk(2'd3, 16'(16'h5000 + i)), "R5 queued flit waits",
                  glb_out, mk(2'd3, 16'(16'h5000 + i)));
        end
        step(EMPTY_SLOT, EMPTY_SLOT);
        check(glb_out == x, "R5 injected into empty slot", glb_out, x);
        step(EMPTY_SLOT, EMPTY_SLOT);
    endtask

    task automatic t_full_local;
        flit_t p [1:6];
        flit_t exp_seq [0:5];
        int    seen [1:6];
        int    k;
        for (int i = 1; i <= 6; i++) begin
            p[i] = mk(2'd1, 16'(16'h6000 + i));
            seen[i] = 0;
        end
        // fill the queue while the global ring is saturated
        for (int i = 1; i <= 4; i++) begin
            step(p[i], mk(2'd3, 16'(16'h7000 + i)));
            check(loc_out == '0 && !loc_deflect, "R6 accepted below depth", loc_out, '0);
        end
        step(p[5], mk(2'd3, 16'h7005));
        check(loc_out == p[5], "R6 full queue deflects", loc_out, p[5]);
        check(loc_deflect, "R6 deflect pulse", {22'd0, loc_deflect}, 23'd1);
        // global slot frees in the same cycle p6 arrives
        step(p[6], EMPTY_SLOT);
        check(loc_out == p[6], "R10 still deflected during drain", loc_out, p[6]);
        check(loc_deflect, "R10 deflect pulse", {22'd0, loc_deflect}, 23'd1);
        if (glb_out == p[1]) seen[1]++;
        check(glb_out == p[1], "R8 oldest first", glb_out, p[1]);
        // retry the deflected flits after their lap
        step(p[5], EMPTY_SLOT);
        check(loc_out == '0 && !loc_deflect, "R7 retry accepted", loc_out, '0);
        check(glb_out == p[2], "R8 order", glb_out, p[2]);
        seen[2] += (glb_out == p[2]);
        step(p[6], EMPTY_SLOT);
        check(loc_out == '0 && !loc_deflect, "R7 second retry accepted", loc_out, '0);
        check(glb_out == p[3], "R8 order", glb_out, p[3]);
        seen[3] += (glb_out == p[3]);
        exp_seq[0] = p[4]; exp_seq[1] = p[5]; exp_seq[2] = p[6];
        k = 0;
        for (int c = 0; c < 6; c++) begin
            step(EMPTY_SLOT, EMPTY_SLOT);
            for (int i = 1; i <= 6; i++)
                if (glb_out == p[i]) seen[i]++;
            if (k < 3) begin
                check(glb_out == exp_seq[k], "R8 drain order", glb_out, exp_seq[k]);
                k++;
            end else begin
                check(glb_out == '0, "R9 no extra flit", glb_out, '0);
            end
        end
        for (int i = 1; i <= 6; i++)
            check(seen[i] == 1, "R9 delivered exactly once", 23'(seen[i]), 23'd1);
    endtask

    task automatic t_full_global;
        flit_t q [1:5];
        for (int i = 1; i <= 5; i++)
            q[i] = mk(2'd0, 16'(16'h8000 + i));
        for (int i = 1; i <= 4; i++)
            step(mk(2'd0, 16'(16'h9000 + i)), q[i]);
        step(mk(2'd0, 16'h9005), q[5]);
        check(glb_out == q[5] && glb_deflect, "R6 global side deflects", glb_out, q[5]);
        step(EMPTY_SLOT, EMPTY_SLOT);
        check(!glb_deflect, "R6 pulse lasts one cycle", {22'd0, glb_deflect}, '0);
        check(loc_out == q[1], "R4 queued flit delivered", loc_out, q[1]);
        for (int i = 0; i < 4; i++)
            step(EMPTY_SLOT, EMPTY_SLOT);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        t_reset();
        t_pass();
        t_cross();
        t_priority();
        t_full_local();
        t_full_global();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule